// File: doc/BRIEF.md
# Shared-Bus Serial DAC Write Master

This block sits on the host side of a serial link that fans out to several 14-bit voltage DACs. All converters share one serial clock line and one data line; each has its own active-low select. A client hands the block a 14-bit code, a target index and a flag that asks for a load strobe, using a valid/ready handshake. The block then drives one select low and sends a 16-bit frame. The frame is two zero padding bits followed by the code, most significant bit first. Data changes on the falling clock edge, so each slave can sample on the rising edge.

The serial clock runs only inside a frame and rests low at all other times. This keeps digital feedthrough into the analog outputs small. After the select returns high, the block can send an active-low load pulse, which meets a setup time after the select rises and a minimum width. All timing comes from cycle counts that are worked out from the system clock frequency and the nanosecond limits, given as parameters. The block accepts no new request until the frame, any strobe and the minimum select-high gap have all passed.

Top module: `dac_frame_writer`

## Requirements
- R1: After reset every select is high, the serial clock is low, the load strobe is high and the request port is ready.
- R2: Each frame has exactly 16 rising serial-clock edges. The bits sampled on them are two zeros and then the 14-bit code, most significant bit first.
- R3: While a select is low, the data line changes only in the cycle where the serial clock falls.
- R4: Every high phase and every low phase of the serial clock inside a frame lasts H system cycles, where H = ceil(f_clk / (2 * f_sclk_max)) and H is at least 1.
- R5: For the whole frame exactly one select is low: bit i of the select vector, where i is the requested index. At no time is more than one select low.
- R6: The select falls H cycles before the first rising serial-clock edge. It rises H cycles after the last falling edge.
- R7: The serial clock is low whenever no select is low.
- R8: When a strobe is requested, the strobe falls after the select has been high for S = ceil(t_setup * f_clk) cycles. It stays low for W = ceil(t_width * f_clk) cycles. Each count is at least 1.
- R9: When no strobe is requested, the strobe stays high for the whole transaction.
- R10: Between two frames the select stays high for at least G = ceil(t_gap * f_clk) cycles.
- R11: Ready is low from the acceptance edge for exactly H + 32*H + G cycles, plus S + W when a strobe is requested.
- R12: The strobe is low only while every select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted on this edge if valid |
| req_code | input | CODE_W | Code to send |
| req_dev | input | IDX_W | Index of the target converter |
| req_load | input | 1 | Issue a load strobe after the frame |
| sclk | output | 1 | Gated serial clock, idles low |
| sdo | output | 1 | Serial data, changes on falling sclk |
| cs_n | output | NUM_DEV | Decoded active-low selects |
| load_n | output | 1 | Active-low load strobe |

## Verification
The bench builds the block with four targets, a 100 MHz system clock, a 25 MHz serial limit, a 30 ns gap, a 40 ns strobe setup and a 50 ns strobe width. That gives H = 2, G = 3, S = 4 and W = 5. Because these counts all differ, a swapped or off-by-one counter changes a measured phase length or the busy time. The sweep covers every target with and without a strobe, the zero, full-scale and alternating codes, and a walking one over all 14 code bits. It issues back-to-back requests so the minimum gap is the only spacing between frames.

// File: rtl/dfw_pkg.sv
`timescale 1ns/1ps
package dfw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_SETUP,
        ST_STROBE,
        ST_GAP
    } dfw_state_e;

    // Cycles covering a time span in ns at a clock of hz, rounded up, at least one.
    function automatic int unsigned ns_to_cycles(longint unsigned ns, longint unsigned hz);
        longint unsigned c;
        c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
        if (c < 64'd1) c = 64'd1;
        return 32'(c);
    endfunction

    // System cycles per half serial period so the serial rate stays at or below the limit.
    function automatic int unsigned half_period_cycles(longint unsigned clk_hz, longint unsigned sclk_hz);
        longint unsigned c;
        c = (clk_hz + 64'd2 * sclk_hz - 64'd1) / (64'd2 * sclk_hz);
        if (c < 64'd1) c = 64'd1;
        return 32'(c);
    endfunction

endpackage

// File: rtl/dfw_select_decode.sv
`timescale 1ns/1ps
module dfw_select_decode #(
    parameter int NUM_DEV = 4,
    parameter int IDX_W   = 2
) (
    input  logic               active,
    input  logic [IDX_W-1:0]   idx,
    output logic [NUM_DEV-1:0] sel_n
);
    // One comparator per target; at most one output can be low.
    for (genvar g = 0; g < NUM_DEV; g++) begin : g_sel
        assign sel_n[g] = !(active && (idx == IDX_W'(g)));
    end
endmodule

// File: rtl/dfw_frame_shift.sv
`timescale 1ns/1ps
module dfw_frame_shift #(
    parameter int CODE_W  = 14,
    parameter int FRAME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [CODE_W-1:0] code,
    output logic              msb
);
    localparam int PAD_W = FRAME_W - CODE_W;

    logic [FRAME_W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load)
            sr_d = {{PAD_W{1'b0}}, code};
        else if (shift)
            sr_d = {sr_q[FRAME_W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign msb = sr_q[FRAME_W-1];
endmodule

// File: rtl/dac_frame_writer.sv
`timescale 1ns/1ps
module dac_frame_writer
    import dfw_pkg::*;
#(
    parameter int              NUM_DEV     = 4,
    parameter int              CODE_W      = 14,
    parameter int              PAD_W       = 2,
    parameter longint unsigned CLK_HZ      = 100_000_000,
    parameter longint unsigned SCLK_MAX_HZ = 25_000_000,
    parameter longint unsigned GAP_NS      = 30,
    parameter longint unsigned SETUP_NS    = 30,
    parameter longint unsigned WIDTH_NS    = 30,
    localparam int             IDX_W       = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [CODE_W-1:0]  req_code,
    input  logic [IDX_W-1:0]   req_dev,
    input  logic               req_load,
    output logic               sclk,
    output logic               sdo,
    output logic [NUM_DEV-1:0] cs_n,
    output logic               load_n
);
    localparam int FRAME_W = CODE_W + PAD_W;
    localparam int BIT_W   = $clog2(FRAME_W);

    localparam int unsigned HALF_C  = half_period_cycles(CLK_HZ, SCLK_MAX_HZ);
    localparam int unsigned LEAD_C  = HALF_C;
    localparam int unsigned GAP_C   = ns_to_cycles(GAP_NS, CLK_HZ);
    localparam int unsigned SETUP_C = ns_to_cycles(SETUP_NS, CLK_HZ);
    localparam int unsigned WIDTH_C = ns_to_cycles(WIDTH_NS, CLK_HZ);

    localparam int unsigned MAX_AB  = (HALF_C > GAP_C) ? HALF_C : GAP_C;
    localparam int unsigned MAX_CD  = (SETUP_C > WIDTH_C) ? SETUP_C : WIDTH_C;
    localparam int unsigned MAX_C   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int          CNT_W   = $clog2(MAX_C + 1);

    typedef struct packed {
        dfw_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic [BIT_W-1:0] bit_idx;
        logic [IDX_W-1:0] dev;
        logic             with_load;
        logic             active;
        logic             sclk;
        logic             load_n;
    } dfw_regs_t;

    localparam dfw_regs_t REGS_RESET = '{
        state:     ST_IDLE,
        cnt:       '0,
        bit_idx:   '0,
        dev:       '0,
        with_load: 1'b0,
        active:    1'b0,
        sclk:      1'b0,
        load_n:    1'b1
    };

    dfw_regs_t          r_d, r_q;
    logic               load_frame, shift_frame;
    logic [NUM_DEV-1:0] sel_n_d, cs_n_q;

    always_comb begin
        r_d         = r_q;
        load_frame  = 1'b0;
        shift_frame = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.state     = ST_LEAD;
                    r_d.cnt       = CNT_W'(LEAD_C - 1);
                    r_d.dev       = req_dev;
                    r_d.with_load = req_load;
                    r_d.active    = 1'b1;
                    load_frame    = 1'b1;
                end
            end
            ST_LEAD: begin
                if (r_q.cnt == '0) begin
                    r_d.state   = ST_HIGH;
                    r_d.sclk    = 1'b1;
                    r_d.cnt     = CNT_W'(HALF_C - 1);
                    r_d.bit_idx = '0;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_HIGH: begin
                if (r_q.cnt == '0) begin
                    r_d.state = ST_LOW;
                    r_d.sclk  = 1'b0;
                    r_d.cnt   = CNT_W'(HALF_C - 1);
                    if (r_q.bit_idx != BIT_W'(FRAME_W - 1))
                        shift_frame = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_LOW: begin
                if (r_q.cnt == '0) begin
                    if (r_q.bit_idx == BIT_W'(FRAME_W - 1)) begin
                        r_d.active = 1'b0;
                        if (r_q.with_load) begin
                            r_d.state = ST_SETUP;
                            r_d.cnt   = CNT_W'(SETUP_C - 1);
                        end else begin
                            r_d.state = ST_GAP;
                            r_d.cnt   = CNT_W'(GAP_C - 1);
                        end
                    end else begin
                        r_d.state   = ST_HIGH;
                        r_d.sclk    = 1'b1;
                        r_d.cnt     = CNT_W'(HALF_C - 1);
                        r_d.bit_idx = r_q.bit_idx + 1'b1;
                    end
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_SETUP: begin
                if (r_q.cnt == '0) begin
                    r_d.state  = ST_STROBE;
                    r_d.load_n = 1'b0;
                    r_d.cnt    = CNT_W'(WIDTH_C - 1);
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_STROBE: begin
                if (r_q.cnt == '0) begin
                    r_d.state  = ST_GAP;
                    r_d.load_n = 1'b1;
                    r_d.cnt    = CNT_W'(GAP_C - 1);
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_GAP: begin
                if (r_q.cnt == '0) r_d.state = ST_IDLE;
                else               r_d.cnt   = r_q.cnt - 1'b1;
            end
            default: r_d = REGS_RESET;
        endcase
    end

    dfw_select_decode #(
        .NUM_DEV (NUM_DEV),
        .IDX_W   (IDX_W)
    ) u_decode (
        .active (r_d.active),
        .idx    (r_d.dev),
        .sel_n  (sel_n_d)
    );

    dfw_frame_shift #(
        .CODE_W  (CODE_W),
        .FRAME_W (FRAME_W)
    ) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_frame),
        .shift (shift_frame),
        .code  (req_code),
        .msb   (sdo)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= REGS_RESET;
            cs_n_q <= '1;
        end else begin
            r_q    <= r_d;
            cs_n_q <= sel_n_d;
        end
    end

    assign req_ready = (r_q.state == ST_IDLE);
    assign sclk      = r_q.sclk;
    assign load_n    = r_q.load_n;
    assign cs_n      = cs_n_q;
endmodule

// File: rtl/dac_frame_writer_chk.sv
`timescale 1ns/1ps
module dac_frame_writer_chk #(
    parameter int NUM_DEV = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_ready,
    input logic               sclk,
    input logic               sdo,
    input logic [NUM_DEV-1:0] cs_n,
    input logic               load_n
);
    logic framing;
    assign framing = !(&cs_n);

    a_r5_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1);

    a_r5_select_held: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(framing) && framing) |-> $stable(cs_n));

    a_r7_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !framing |-> !sclk);

    a_r12_strobe_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |-> !framing);

    a_r11_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (framing || !load_n) |-> !req_ready);

    a_r3_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(framing) && framing && !$fell(sclk)) |-> $stable(sdo));
endmodule

bind dac_frame_writer dac_frame_writer_chk #(.NUM_DEV(NUM_DEV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .sclk      (sclk),
    .sdo       (sdo),
    .cs_n      (cs_n),
    .load_n    (load_n)
);

// File: tb/dac_frame_writer_test.sv
`timescale 1ns/1ps
module dac_frame_writer_test;
    localparam int              CLK_PERIOD = 10;
    localparam int              NDEV       = 4;
    localparam int              CW         = 14;
    localparam longint unsigned F_CLK      = 100_000_000;
    localparam longint unsigned F_SCLK     = 25_000_000;
    localparam longint unsigned T_GAP      = 30;
    localparam longint unsigned T_SETUP    = 40;
    localparam longint unsigned T_WIDTH    = 50;

    // Expected counts from the requirements: 10 ns per cycle.
    localparam int H_E = 2;   // 40 ns serial period, 20 ns per half
    localparam int G_E = 3;   // 30 ns
    localparam int S_E = 4;   // 40 ns
    localparam int W_E = 5;   // 50 ns

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [CW-1:0]   req_code = '0;
    logic [1:0]      req_dev = '0;
    logic            req_load = 1'b0;
    logic            sclk, sdo, load_n;
    logic [NDEV-1:0] cs_n;

    dac_frame_writer #(
        .NUM_DEV(NDEV), .CODE_W(CW), .PAD_W(2),
        .CLK_HZ(F_CLK), .SCLK_MAX_HZ(F_SCLK),
        .GAP_NS(T_GAP), .SETUP_NS(T_SETUP), .WIDTH_NS(T_WIDTH)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_code(req_code), .req_dev(req_dev), .req_load(req_load),
        .sclk(sclk), .sdo(sdo), .cs_n(cs_n), .load_n(load_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Expected transaction, set by the driver before each request.
    logic [CW-1:0] exp_code = '0;
    int            exp_dev  = 0;
    bit            exp_load = 1'b0;
    bit            mon_en   = 1'b0;

    // Monitor state
    bit            p_any = 1'b0, p_sclk = 1'b0, p_sdo = 1'b0, p_load_n = 1'b1, p_ready = 1'b1;
    bit            seen_frame = 1'b0, first_rise = 1'b1, ld_seen = 1'b0;
    logic [15:0]   f_bits = '0;
    int            f_edges = 0, f_lead = 0, hi_run = 0, lo_run = 0;
    int            sel_bad = 0, phase_bad = 0, data_bad = 0, idle_bad = 0, strobe_bad = 0;
    int            gap_run = 0, ld_run = 0, busy = 0;
    logic [NDEV-1:0] sel_seen = '1;
    int            phase_seen = 0;

    always @(negedge clk) begin
        if (rst_n && mon_en) begin
            automatic bit any = !(&cs_n);
            if (any && !p_any) begin
                if (seen_frame) check(gap_run >= G_E, "R10 select high between frames", gap_run, G_E);
                f_bits = '0; f_edges = 0; f_lead = 0; first_rise = 1'b1;
                sel_bad = 0; phase_bad = 0; data_bad = 0; hi_run = 0; lo_run = 0;
            end
            if (any) begin
                if (cs_n != ~(NDEV'(1) << exp_dev)) begin sel_bad++; sel_seen = cs_n; end
                if (!load_n) strobe_bad++;
                if (p_any && (sdo != p_sdo) && !(p_sclk && !sclk)) data_bad++;
                if (sclk) begin
                    if (!p_sclk) begin
                        f_bits = {f_bits[14:0], sdo};
                        f_edges++;
                        if (first_rise) begin
                            check(f_lead == H_E, "R6 select lead before first rise", f_lead, H_E);
                            first_rise = 1'b0;
                        end else if (lo_run != H_E) begin
                            phase_bad++; phase_seen = lo_run;
                        end
                        hi_run = 1;
                    end else hi_run++;
                end else begin
                    if (first_rise) f_lead++;
                    else if (p_sclk) begin
                        if (hi_run != H_E) begin phase_bad++; phase_seen = hi_run; end
                        lo_run = 1;
                    end else lo_run++;
                end
            end
            if (!any && p_any) begin
                check(f_edges == 16, "R2 rising edges per frame", f_edges, 16);
                check(f_bits == {2'b00, exp_code}, "R2 frame bits", f_bits, {2'b00, exp_code});
                check(sel_bad == 0, "R5 decoded select", sel_seen, ~(NDEV'(1) << exp_dev));
                check(phase_bad == 0, "R4 serial phase length", phase_seen, H_E);
                check(data_bad == 0, "R3 data changes on falling edge", data_bad, 0);
                check(lo_run == H_E, "R6 select hold after last fall", lo_run, H_E);
                check(strobe_bad == 0, "R12 strobe inside frame", strobe_bad, 0);
                seen_frame = 1'b1; gap_run = 0; ld_run = 0; ld_seen = 1'b0; strobe_bad = 0;
            end
            if (!any) begin
                if (sclk) idle_bad++;
                if (!load_n && p_load_n) begin
                    ld_seen = 1'b1;
                    check(gap_run == S_E, "R8 strobe setup after select rise", gap_run, S_E);
                end
                if (!load_n) ld_run++;
                if (load_n && !p_load_n)
                    check(ld_run == W_E, "R8 strobe width", ld_run, W_E);
                gap_run++;
            end
            if (!req_ready) busy++;
            if (req_ready && !p_ready) begin
                automatic int exp_busy = H_E + 32 * H_E + G_E + (exp_load ? (S_E + W_E) : 0);
                check(busy == exp_busy, "R11 busy cycles", busy, exp_busy);
                check(idle_bad == 0, "R7 serial clock idle low", idle_bad, 0);
                if (exp_load) check(ld_seen, "R8 strobe issued", ld_seen, 1);
                else          check(!ld_seen, "R9 no strobe when not requested", ld_seen, 0);
                busy = 0; idle_bad = 0;
            end
            p_any = any; p_sclk = sclk; p_sdo = sdo; p_load_n = load_n; p_ready = req_ready;
        end
    end

    task automatic send(input logic [CW-1:0] code, input int dev, input bit ld);
        exp_code = code; exp_dev = dev; exp_load = ld;
        req_code = code; req_dev = 2'(dev); req_load = ld; req_valid = 1'b1;
        @(negedge clk);
        #1 req_valid = 1'b0;
        do @(negedge clk); while (!req_ready);
        #1;
    endtask

    // Watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(cs_n == '1, "R1 selects high", cs_n, 4'hF);
        check(sclk == 1'b0, "R1 serial clock low", sclk, 0);
        check(load_n == 1'b1, "R1 strobe high", load_n, 1);
        check(req_ready == 1'b1, "R1 ready", req_ready, 1);
        #1 mon_en = 1'b1;

        // Every target, with and without strobe, over corner codes
        for (int d = 0; d < NDEV; d++) begin
            for (int l = 0; l < 2; l++) begin
                send(14'h0000, d, l[0]);
                send(14'h3FFF, d, l[0]);
                send(14'h2000, d, l[0]);
                send(14'h1555, d, l[0]);
                send(14'h2AAA, d, l[0]);
                send(14'h0001, d, l[0]);
            end
        end
        // Walking one over every code bit
        for (int i = 0; i < CW; i++) send(CW'(1) << i, i % NDEV, i[0]);
        // Walking zero
        for (int i = 0; i < CW; i++) send(~(CW'(1) << i), (i + 1) % NDEV, !i[0]);

        repeat (5) @(negedge clk);
        check(cs_n == '1 && sclk == 1'b0 && load_n == 1'b1, "R7 final idle", {cs_n, sclk, load_n}, 6'h3D);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule